// File: doc/BRIEF.md
# Watchdog Frequency-Recovery Controller

This block keeps the frequency-selection state of a clock generator and protects it against a hang after a frequency change. Software writes configuration bytes through a simple write port. The block holds a 5-bit select code that is latched from strap pins while reset is held, a software select code and an override bit, a programmable N/M pair, a recovery N/M pair, and a recovery-source bit. From these it drives the active select code, N, M, a programmable-mode flag and a one-cycle load strobe toward the PLL.

A software load is an accepted write to the programmable pair. It arms a countdown watchdog. The countdown is clocked by one of two slow tick inputs, a short unit and a long unit, and a prescaler bit picks between them. If software does not disarm the watchdog before the count runs out, the block sets a sticky timeout flag and switches the outputs to a recovery frequency. It can also pull an active-low system reset low for a fixed number of cycles. A separate enable makes every software frequency load pull the same reset.

Top module: `freq_recovery_ctrl`

## Requirements
- R1: While `rst_n` is low, the block captures `strap_fs`. After reset, `sel_code` equals the captured code, `n_val`=0, `m_val`=0, `prog_mode`=0, `load_strobe`=0, `timeout_flag`=0 and `sys_rst_n`=1.
- R2: The write port uses these addresses: 0 control, 1 watchdog config, 2 software code, 3 N, 4 M, 5 recovery N, 6 recovery M. The control byte has these bits: bit0 override, bit1 programmable enable, bit2 recovery source, bit3 watchdog enable, bit4 reset-on-timeout, bit5 reset-on-change, bit6 clear status. Outside recovery, `sel_code` is the strap code when override is 0 and the software code when override is 1.
- R3: Outside recovery, `prog_mode` follows the programmable enable bit. `n_val`/`m_val` show the programmable pair. The override bit still picks `sel_code` while `prog_mode` is 1.
- R4: A write to any of addresses 3 to 6 that is accepted pulses `load_strobe` high for exactly the cycle after the write edge. A new programmable value appears on `n_val`/`m_val` in that same cycle.
- R5: A pair write is accepted only if the resulting N is strictly greater than the resulting M. A write that is rejected leaves the register unchanged and gives no strobe. This includes the N = M boundary.
- R6: The watchdog config byte holds the timeout T in bits 4:0 (reset value 31) and the prescaler in bit5. Bit5 = 0 counts `tick_short` and bit5 = 1 counts `tick_long`. The other tick input is ignored. The timeout fires on the T-th counted tick after arming.
- R7: On timeout, `timeout_flag` rises and `load_strobe` pulses in the same cycle, after the edge that counted the last tick.
- R8: During recovery with recovery source 0, `sel_code` is the strap code, `prog_mode` is 0, and `n_val`/`m_val` show the recovery pair.
- R9: `timeout_flag` stays set until a control write with bit6 = 1. A control write with bit6 = 0 leaves it set. Clearing it ends recovery, restores the normal outputs and pulses `load_strobe`.
- R10: With reset-on-change set, an accepted programmable-pair write drives `sys_rst_n` low for RST_CYCLES cycles, starting the cycle after the write.
- R11: During recovery with recovery source 1, `prog_mode` is 1, `n_val`/`m_val` show the recovery pair, and `sel_code` follows the override bit. With reset-on-timeout set, the timeout drives `sys_rst_n` low for RST_CYCLES cycles.
- R12: When the watchdog enable bit is 0, the countdown is stopped and reloaded, and ticks produce no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps captured while low |
| strap_fs | input | 5 | Strap frequency code |
| tick_short | input | 1 | Short-unit time-base pulse |
| tick_long | input | 1 | Long-unit time-base pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| sel_code | output | 5 | Active frequency select code |
| n_val | output | 8 | Active N value |
| m_val | output | 7 | Active M value |
| prog_mode | output | 1 | N/M sets the frequency |
| load_strobe | output | 1 | One-cycle frequency load pulse |
| timeout_flag | output | 1 | Sticky watchdog timeout status |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
Every result is due one edge after the stimulus that causes it. This holds for register writes and code selection, the strobe, the timeout flag and the start of a reset pulse. The reset then stays low for exactly RST_CYCLES samples and is high on the next one. The driver changes inputs on the falling edge and queues each expectation with the cycle number of the rising edge that should produce it. The monitor samples 1 ns after each rising edge and compares only the entries due in that cycle, so a result that comes early or late is reported against its cycle.

// File: rtl/frc_pkg.sv
// Package: field widths, register addresses and control-bit positions
// shared by the frequency-recovery controller and its submodules.
package frc_pkg;
    localparam int SEL_W = 5;   // select code width
    localparam int N_W   = 8;   // N value width
    localparam int M_W   = 7;   // M value width
    localparam int TO_W  = 5;   // watchdog timeout field width
    localparam int AW    = 3;   // register address width
    localparam int DW    = 8;   // register data width

    typedef enum logic [AW-1:0] {
        A_CTRL  = 3'd0,
        A_WDCFG = 3'd1,
        A_SWSEL = 3'd2,
        A_PN    = 3'd3,
        A_PM    = 3'd4,
        A_RN    = 3'd5,
        A_RM    = 3'd6
    } reg_addr_e;

    localparam int CB_OVR   = 0;
    localparam int CB_PROG  = 1;
    localparam int CB_RSRC  = 2;
    localparam int CB_WDEN  = 3;
    localparam int CB_RSTTO = 4;
    localparam int CB_RSTFC = 5;
    localparam int CB_CLR   = 6;
    localparam int WB_PRE   = 5;
endpackage

// File: rtl/frc_regs.sv
// Register file: latches straps during reset, holds the configuration and
// both N/M pairs, and rejects any pair write that would leave N <= M.
// Assumes one write per cycle; a pair write is checked against the stored
// other half of the same pair.
module frc_regs
    import frc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [SEL_W-1:0] strap_fs,
    output logic [SEL_W-1:0] strap_q,
    output logic [SEL_W-1:0] sw_sel,
    output logic             ovr,
    output logic             prog_en,
    output logic             rec_src,
    output logic             wd_en,
    output logic             rst_to_en,
    output logic             rst_fc_en,
    output logic [TO_W-1:0]  timeout,
    output logic             prescale,
    output logic [N_W-1:0]   pn,
    output logic [M_W-1:0]   pm,
    output logic [N_W-1:0]   rn,
    output logic [M_W-1:0]   rm,
    output logic             sw_load,
    output logic             rec_load,
    output logic             clr_req
);
    localparam int PADW = N_W - M_W;

    logic acc_pn, acc_pm, acc_rn, acc_rm;

    // Decode writes and check the N > M rule for each pair half.
    always_comb begin
        acc_pn   = wr_en && (wr_addr == A_PN) && (wr_data[N_W-1:0] > {{PADW{1'b0}}, pm});
        acc_pm   = wr_en && (wr_addr == A_PM) && (pn > {{PADW{1'b0}}, wr_data[M_W-1:0]});
        acc_rn   = wr_en && (wr_addr == A_RN) && (wr_data[N_W-1:0] > {{PADW{1'b0}}, rm});
        acc_rm   = wr_en && (wr_addr == A_RM) && (rn > {{PADW{1'b0}}, wr_data[M_W-1:0]});
        sw_load  = acc_pn || acc_pm;
        rec_load = acc_rn || acc_rm;
        clr_req  = wr_en && (wr_addr == A_CTRL) && wr_data[CB_CLR];
    end

    // Register storage; straps sampled while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q   <= strap_fs;
            sw_sel    <= '0;
            ovr       <= 1'b0;
            prog_en   <= 1'b0;
            rec_src   <= 1'b0;
            wd_en     <= 1'b0;
            rst_to_en <= 1'b0;
            rst_fc_en <= 1'b0;
            timeout   <= '1;
            prescale  <= 1'b0;
            pn        <= '0;
            pm        <= '0;
            rn        <= '0;
            rm        <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ovr       <= wr_data[CB_OVR];
                    prog_en   <= wr_data[CB_PROG];
                    rec_src   <= wr_data[CB_RSRC];
                    wd_en     <= wr_data[CB_WDEN];
                    rst_to_en <= wr_data[CB_RSTTO];
                    rst_fc_en <= wr_data[CB_RSTFC];
                end
                A_WDCFG: begin
                    timeout  <= wr_data[TO_W-1:0];
                    prescale <= wr_data[WB_PRE];
                end
                A_SWSEL: sw_sel <= wr_data[SEL_W-1:0];
                A_PN: if (acc_pn) pn <= wr_data[N_W-1:0];
                A_PM: if (acc_pm) pm <= wr_data[M_W-1:0];
                A_RN: if (acc_rn) rn <= wr_data[N_W-1:0];
                A_RM: if (acc_rm) rm <= wr_data[M_W-1:0];
                default: ;
            endcase
        end
    end

    // Stored programmable pair is either untouched or valid.
    assert_prog_pair_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pn == '0) && (pm == '0)) || (pn > {{PADW{1'b0}}, pm}));
    // Stored recovery pair is either untouched or valid.
    assert_rec_pair_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rn == '0) && (rm == '0)) || (rn > {{PADW{1'b0}}, rm}));
endmodule

// File: rtl/frc_wdog.sv
// Watchdog countdown: arms on a software load and counts the tick selected
// by the prescaler. It produces a one-cycle expire on the T-th counted tick
// (a timeout of 0 expires on the first tick). Assumes ticks are single-cycle
// pulses.
module frc_wdog #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wd_en,
    input  logic [TW-1:0] timeout,
    input  logic          prescale,
    input  logic          tick_short,
    input  logic          tick_long,
    input  logic          arm,
    output logic          expire
);
    logic [TW-1:0] cnt_q;
    logic          run_q;
    logic          tick;

    // Pick the time base and detect the final counted tick.
    always_comb begin
        tick   = prescale ? tick_long : tick_short;
        expire = run_q && wd_en && !arm && tick && (cnt_q <= TW'(1));
    end

    // Countdown state: disable reloads, arm restarts, expiry stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!wd_en) begin
            run_q <= 1'b0;
            cnt_q <= timeout;
        end else if (arm) begin
            run_q <= 1'b1;
            cnt_q <= timeout;
        end else if (expire) begin
            run_q <= 1'b0;
            cnt_q <= timeout;
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_disabled_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> !run_q);
    assert_single_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run_q);
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wd_en && !arm && tick && (cnt_q > TW'(1))) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/frc_rstgen.sv
// Reset pulse generator: a trigger drives rst_n_o low for exactly
// RST_CYCLES cycles. A new trigger during a pulse restarts it.
module frc_rstgen #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic rst_n_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load the pulse length on a trigger, then count down to release.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (trigger)    cnt_q <= CW'(RST_CYCLES);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    // Output is low while the count is non-zero.
    always_comb rst_n_o = (cnt_q == '0);

    assert_reset_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_n_o) |-> $past(trigger));
endmodule

// File: rtl/freq_recovery_ctrl.sv
// Top level: joins the register file, the watchdog and the reset generator.
// It keeps the sticky timeout (recovery) state, selects the active
// code/N/M, and registers the load strobe.
module freq_recovery_ctrl
    import frc_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] strap_fs,
    input  logic             tick_short,
    input  logic             tick_long,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [SEL_W-1:0] sel_code,
    output logic [N_W-1:0]   n_val,
    output logic [M_W-1:0]   m_val,
    output logic             prog_mode,
    output logic             load_strobe,
    output logic             timeout_flag,
    output logic             sys_rst_n
);
    logic [SEL_W-1:0] strap_q, sw_sel, code_norm;
    logic             ovr, prog_en, rec_src, wd_en, rst_to_en, rst_fc_en, prescale;
    logic [TO_W-1:0]  timeout;
    logic [N_W-1:0]   pn, rn;
    logic [M_W-1:0]   pm, rm;
    logic             sw_load, rec_load, clr_req, expire;
    logic             status_q, strobe_q;

    frc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .strap_fs(strap_fs), .strap_q(strap_q), .sw_sel(sw_sel), .ovr(ovr),
        .prog_en(prog_en), .rec_src(rec_src), .wd_en(wd_en), .rst_to_en(rst_to_en),
        .rst_fc_en(rst_fc_en), .timeout(timeout), .prescale(prescale),
        .pn(pn), .pm(pm), .rn(rn), .rm(rm),
        .sw_load(sw_load), .rec_load(rec_load), .clr_req(clr_req)
    );

    frc_wdog #(.TW(TO_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .timeout(timeout), .prescale(prescale),
        .tick_short(tick_short), .tick_long(tick_long), .arm(sw_load), .expire(expire)
    );

    frc_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n),
        .trigger((sw_load && rst_fc_en) || (expire && rst_to_en)),
        .rst_n_o(sys_rst_n)
    );

    // Sticky status (doubles as recovery state) and the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= sw_load || rec_load || expire || (clr_req && status_q);
            if (expire)       status_q <= 1'b1;
            else if (clr_req) status_q <= 1'b0;
        end
    end

    // Select the active frequency from the normal or recovery source.
    always_comb begin
        code_norm = ovr ? sw_sel : strap_q;
        if (status_q && !rec_src) begin
            sel_code  = strap_q;
            prog_mode = 1'b0;
            n_val     = rn;
            m_val     = rm;
        end else if (status_q) begin
            sel_code  = code_norm;
            prog_mode = 1'b1;
            n_val     = rn;
            m_val     = rm;
        end else begin
            sel_code  = code_norm;
            prog_mode = prog_en;
            n_val     = pn;
            m_val     = pm;
        end
        load_strobe  = strobe_q;
        timeout_flag = status_q;
    end

    assert_timeout_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> load_strobe);
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !clr_req) |=> timeout_flag);
endmodule

// File: tb/tb_freq_recovery_ctrl.sv
// Scoreboard bench: driver tasks push expected output vectors tagged with
// the cycle they are due in; a monitor pops and compares them.
module tb_freq_recovery_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap_fs = 5'h16;
    logic       tick_short = 1'b0, tick_long = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] sel_code;
    logic [7:0] n_val;
    logic [6:0] m_val;
    logic       prog_mode, load_strobe, timeout_flag, sys_rst_n;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    // Expected state, maintained from the requirements.
    logic [4:0] e_sel = 5'h16;
    logic [7:0] e_n = 0;
    logic [6:0] e_m = 0;
    logic       e_prog = 0, e_stat = 0;

    typedef struct {
        int          due;
        string       tag;
        logic [23:0] v;
    } item_t;
    item_t q[$];

    freq_recovery_ctrl #(.RST_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .tick_short(tick_short),
        .tick_long(tick_long), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_code(sel_code), .n_val(n_val), .m_val(m_val), .prog_mode(prog_mode),
        .load_strobe(load_strobe), .timeout_flag(timeout_flag), .sys_rst_n(sys_rst_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input string tag, input int off, input logic stb, input logic rsn);
        item_t it;
        it.due = cyc + off;
        it.tag = tag;
        it.v   = {e_sel, e_n, e_m, e_prog, stb, e_stat, rsn};
        q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_short = 1'b0; tick_long = 1'b0;
    endtask

    task automatic tk(input logic lng);
        @(negedge clk);
        wr_en = 1'b0; tick_short = !lng; tick_long = lng;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0; tick_short = 1'b0; tick_long = 1'b0;
        end
    endtask

    // Monitor: compare every expectation due in this cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [23:0] got;
                it  = q.pop_front();
                got = {sel_code, n_val, m_val, prog_mode, load_strobe, timeout_flag, sys_rst_n};
                checks++;
                if (it.due != cyc || got !== it.v) begin
                    errors++;
                    $display("FAIL %s (cycle %0d): got %h expected %h", it.tag, cyc, got, it.v);
                end
            end
        end
    end

    // Watchdog on the bench itself.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        push("R1 reset state", 1, 0, 1);
        // R2: software code ignored while override is 0, used when 1
        wr(3'd2, 8'h0B); push("R2 override0 keeps strap", 1, 0, 1);
        wr(3'd0, 8'h01); e_sel = 5'h0B; push("R2 override1 software code", 1, 0, 1);
        // R4: accepted N write
        wr(3'd3, 8'd100); e_n = 100; push("R4 N load strobe", 1, 1, 1);
        idle(1); push("R4 strobe one cycle", 1, 0, 1);
        // R5: rejected M writes, then boundary accept
        wr(3'd4, 8'd120); push("R5 M above N rejected", 1, 0, 1);
        wr(3'd4, 8'd100); push("R5 M equal N rejected", 1, 0, 1);
        wr(3'd4, 8'd99);  e_m = 99; push("R4 M load accepted", 1, 1, 1);
        // R3: programmable mode keeps override code
        wr(3'd0, 8'h03); e_prog = 1; push("R3 prog mode on", 1, 0, 1);
        // R6/R7/R8: default timeout 31 short ticks
        wr(3'd0, 8'h0B); push("R12 enable only", 1, 0, 1);
        wr(3'd3, 8'd130); e_n = 130; push("R4 arm load", 1, 1, 1);
        for (int i = 0; i < 3; i++) tk(1'b1);
        push("R6 long tick ignored", 1, 0, 1);
        for (int i = 0; i < 30; i++) tk(1'b0);
        push("R6 no timeout at tick 30", 1, 0, 1);
        tk(1'b0);
        e_stat = 1; e_sel = 5'h16; e_prog = 0; e_n = 0; e_m = 0;
        push("R7 R8 timeout to strap code", 1, 1, 1);
        idle(1); push("R7 strobe one cycle", 1, 0, 1);
        // R9: writing 0 leaves status; writing 1 clears
        wr(3'd0, 8'h0B); push("R9 write 0 keeps status", 1, 0, 1);
        wr(3'd0, 8'h4B);
        e_stat = 0; e_sel = 5'h0B; e_prog = 1; e_n = 130; e_m = 99;
        push("R9 clear restores outputs", 1, 1, 1);
        // R10: reset pulse on frequency change
        wr(3'd0, 8'h23); push("R10 setup", 1, 0, 1);
        wr(3'd3, 8'd140); e_n = 140;
        push("R10 reset low 1", 1, 1, 0);
        push("R10 reset low 2", 2, 0, 0);
        push("R10 reset low 3", 3, 0, 0);
        push("R10 reset low 4", 4, 0, 0);
        push("R10 reset released", 5, 0, 1);
        idle(5);
        // R11: recovery pair and reset on timeout
        wr(3'd0, 8'h03); push("R11 setup", 1, 0, 1);
        wr(3'd5, 8'd200); push("R4 recovery N strobe", 1, 1, 1);
        wr(3'd6, 8'd10);  push("R4 recovery M strobe", 1, 1, 1);
        wr(3'd1, 8'h22);  push("R6 long prescale config", 1, 0, 1);
        wr(3'd0, 8'h1F);  push("R11 enable", 1, 0, 1);
        wr(3'd3, 8'd150); e_n = 150; push("R4 rearm load", 1, 1, 1);
        for (int i = 0; i < 3; i++) tk(1'b0);
        push("R6 short tick ignored", 1, 0, 1);
        tk(1'b1); push("R6 first long tick", 1, 0, 1);
        tk(1'b1);
        e_stat = 1; e_n = 200; e_m = 10; e_prog = 1; e_sel = 5'h0B;
        push("R11 recovery pair reset low 1", 1, 1, 0);
        push("R11 reset low 2", 2, 0, 0);
        push("R11 reset low 3", 3, 0, 0);
        push("R11 reset low 4", 4, 0, 0);
        push("R11 reset released", 5, 0, 1);
        idle(5);
        wr(3'd0, 8'h5F); e_stat = 0; e_n = 150; e_m = 99;
        push("R9 clear after recovery pair", 1, 1, 1);
        // R12: disabling the watchdog stops a running count
        wr(3'd1, 8'h01); push("R12 config", 1, 0, 1);
        wr(3'd3, 8'd160); e_n = 160; push("R12 arm", 1, 1, 1);
        wr(3'd0, 8'h17); push("R12 disable", 1, 0, 1);
        for (int i = 0; i < 3; i++) tk(1'b0);
        push("R12 no timeout when disabled", 1, 0, 1);
        idle(3);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL queue: %0d expectations left, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule